// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Access

The block gathers a configurable number of interrupt request lines, up to 32, into one interrupt line for a processor. An elaboration-time mask sets each line to edge-sensitive or level-sensitive. Requests are latched into a status word, filtered by a per-source enable word, and ranked so that software can read one vector word. That word gives the index of the request to service next.

Software reaches the block over a plain 32-bit register bus with byte offsets. Reads are combinational from the address. Writes take effect on the clock edge on which `bus_sel` and `bus_wr` are both high. Two master bits gate the block. One controls whether hardware requests are latched at all. The other controls whether the processor line can assert.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the status, enable and master registers read zero, the vector word reads 0xFFFFFFFF and `irq_out` is low.
- R2: Requests enter status only while master bit 1 (latch enable) is set. While it is clear, no status bit goes from 0 to 1.
- R3: `irq_out` is high exactly one clock after a cycle in which master bit 0 (output enable) was set and at least one status bit was also enabled. Otherwise it is low.
- R4: A write to offset 0x0C clears every status bit that is one in the write data. A write of 0xFFFFFFFF clears all of them.
- R5: A write to offset 0x10 sets, and a write to offset 0x14 clears, the enable bits that are one in the write data, and leaves the other bits unchanged. A direct write to offset 0x08 loads the enable word, so writing zero disables every source.
- R6: An input whose kind-mask bit is 1 latches once per rising edge and stays clear after an acknowledge while still high. An input whose kind-mask bit is 0 is level-sensitive: its status bit is set again on every cycle it is high, so an acknowledge while it is high has no effect.
- R7: The vector word at offset 0x18 reads 0xFFFFFFFF when no bit is both pending and enabled.
- R8: When bits are both pending and enabled, the vector word returns the lowest such index.
- R9: Only the low `N_SRC` bits of each register exist. Higher bits read zero, writes to them are ignored, and kind-mask bits at or above `N_SRC` are ignored.
- R10: Register map: status 0x00 (read-only), pending = status AND enable at 0x04, enable 0x08, acknowledge 0x0C, set-enable 0x10, clear-enable 0x14, vector 0x18, master 0x1C (bits 1:0). The write-only offsets 0x0C, 0x10 and 0x14 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Interrupt request lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
A corrupted status or enable bit shows up in the same cycle in the pending and vector words, because both are read combinationally. On `irq_out` it shows up one clock later. A wrong edge-detect copy shows as a second latch of an edge source that is held high, or as a missed latch, and this can be read in status right after the next acknowledge. A priority fault shows as a wrong index as soon as two enabled sources are pending together, so the bench arranges that case, masks the lower source off, and reads the vector word again.

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int          N_SRC     = 32,
  parameter logic [31:0] EDGE_KIND = 32'h0000_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [4:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_out
);
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [N_SRC-1:0] EDGE_M = EDGE_KIND[N_SRC-1:0];

  localparam logic [2:0] A_STAT = 3'd0, A_PEND = 3'd1, A_ENA = 3'd2, A_ACK = 3'd3,
                         A_SET  = 3'd4, A_CLR  = 3'd5, A_VEC = 3'd6, A_MST = 3'd7;

  logic [N_SRC-1:0] status, enable, src_q, hits, ack_m, pend;
  logic [1:0]       mst;
  logic             irq_q;
  logic [31:0]      vec;

  wire              wr_en = bus_sel && bus_wr;
  wire [2:0]        reg_sel = bus_addr[4:2];
  wire [N_SRC-1:0]  wmask = bus_wdata[N_SRC-1:0];

  assign hits  = (EDGE_M & irq_in & ~src_q) | (~EDGE_M & irq_in);
  assign ack_m = (wr_en && reg_sel == A_ACK) ? wmask : '0;
  assign pend  = status & enable;
  assign irq_out = irq_q;

  always_comb begin
    vec = 32'hFFFF_FFFF;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pend[i]) vec = 32'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
      src_q  <= '0;
      mst    <= '0;
      irq_q  <= 1'b0;
    end else begin
      src_q  <= irq_in;
      status <= (status & ~ack_m) | (mst[1] ? hits : '0);
      irq_q  <= mst[0] && (|pend);
      if (wr_en) begin
        case (reg_sel)
          A_ENA:   enable <= wmask;
          A_SET:   enable <= enable | wmask;
          A_CLR:   enable <= enable & ~wmask;
          A_MST:   mst    <= bus_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (reg_sel)
      A_STAT:  bus_rdata = 32'(status);
      A_PEND:  bus_rdata = 32'(pend);
      A_ENA:   bus_rdata = 32'(enable);
      A_VEC:   bus_rdata = vec;
      A_MST:   bus_rdata = {30'd0, mst};
      default: bus_rdata = '0;
    endcase
  end

  AST_OUT_NEEDS_ME: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(mst[0])); // R3

  AST_NO_LATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mst[1] |=> ((status & ~$past(status)) == '0)); // R2

  AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & EDGE_M & ~($past(irq_in) & ~$past(src_q))) == '0)); // R6

  AST_VEC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != 32'hFFFF_FFFF) |-> pend[vec[IW-1:0]]); // R8

  AST_VEC_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (status & enable) == '0 |-> (vec == 32'hFFFF_FFFF)); // R7

endmodule

// File: tb/tb_irq_vec_ctrl.sv
module tb_irq_vec_ctrl;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  always #2 clk = ~clk;

  irq_vec_ctrl #(.N_SRC(N), .EDGE_KIND(32'hFFFF_FF0F)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(src), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  smp_ev;
  int checks = 0, errors = 0;
  bit done = 0;

  always begin
    @(smp_ev);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? {31'd0, irq_out} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    it.is_irq = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> smp_ev;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1; it.exp = {31'd0, e}; it.tag = tag;
    q.push_back(it);
    -> smp_ev;
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(5'h00, 32'h0, "R1 status");
    rd(5'h08, 32'h0, "R1 enable");
    rd(5'h1C, 32'h0, "R1 master");
    rd(5'h18, 32'hFFFF_FFFF, "R1 vector");
    chk_irq(0, "R1 irq_out");

    // R2 latch enable off: pulse is lost
    @(negedge clk) src[0] = 1;
    @(negedge clk) src[0] = 0;
    rd(5'h00, 32'h0, "R2 no latch while off");

    // R2 latch enable on, output enable off
    wr(5'h1C, 32'h2);
    @(negedge clk) src[1] = 1;
    @(negedge clk) src[1] = 0;
    rd(5'h00, 32'h02, "R2 latched");
    rd(5'h04, 32'h0, "R10 pending masked");
    wr(5'h10, 32'h02);
    rd(5'h04, 32'h02, "R10 pending");
    rd(5'h18, 32'h1, "R8 vector one source");
    chk_irq(0, "R3 gated by output enable");

    wr(5'h1C, 32'h3);
    chk_irq(1, "R3 asserted");
    rd(5'h1C, 32'h3, "R10 master readback");

    // R4 acknowledge
    wr(5'h0C, 32'h02);
    rd(5'h00, 32'h0, "R4 ack clears");
    rd(5'h18, 32'hFFFF_FFFF, "R7 vector none");
    chk_irq(0, "R3 drops");

    // R6 level source ignores ack while high
    @(negedge clk) src[5] = 1;
    rd(5'h00, 32'h20, "R6 level latched");
    wr(5'h0C, 32'h20);
    rd(5'h00, 32'h20, "R6 level ack while high");
    @(negedge clk) src[5] = 0;
    wr(5'h0C, 32'h20);
    rd(5'h00, 32'h0, "R6 level ack after drop");

    // R5 / R8 priority and enable aliases
    wr(5'h10, 32'h28);
    rd(5'h08, 32'h2A, "R5 set-enable");
    @(negedge clk) begin src[3] = 1; src[5] = 1; end
    @(negedge clk) src[3] = 0;
    rd(5'h18, 32'h3, "R8 lowest wins");
    rd(5'h04, 32'h28, "R10 pending two");
    wr(5'h14, 32'h08);
    rd(5'h08, 32'h22, "R5 clear-enable");
    rd(5'h18, 32'h5, "R8 next after mask");
    rd(5'h00, 32'h28, "R5 status kept when masked");
    chk_irq(1, "R3 high with source 5");

    wr(5'h08, 32'h0);
    rd(5'h08, 32'h0, "R5 direct zero");
    rd(5'h18, 32'hFFFF_FFFF, "R7 none enabled");
    chk_irq(0, "R3 low after disable");

    // R9 width
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, 32'h0000_00FF, "R9 upper bits absent");
    rd(5'h18, 32'h3, "R8 after re-enable");
    @(negedge clk) src[5] = 0;
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h00, 32'h0, "R4 ack all");

    // R6 edge held high latches once
    @(negedge clk) src[2] = 1;
    rd(5'h00, 32'h04, "R6 edge latched");
    wr(5'h0C, 32'h04);
    rd(5'h00, 32'h0, "R6 edge held no relatch");
    @(negedge clk) src[2] = 0;

    // R9 kind bits above N ignored: source 7 is level
    @(negedge clk) src[7] = 1;
    wr(5'h0C, 32'h80);
    rd(5'h00, 32'h80, "R9 source 7 level");
    @(negedge clk) src[7] = 0;
    wr(5'h0C, 32'h80);

    // R10 write-only offsets
    rd(5'h0C, 32'h0, "R10 ack reads zero");
    rd(5'h10, 32'h0, "R10 set reads zero");
    rd(5'h14, 32'h0, "R10 clear reads zero");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    report();
  end
endmodule